// File: doc/BRIEF.md
# Flow-Through Synchronous Burst Memory

This block is a synthesizable behavioural model of a synchronous static memory. Address and write controls are captured on the rising clock edge. Read data comes straight out of the array in the same cycle, with no output register. A burst starts when either of two address strobes is sampled low. The sampled address becomes the burst base. A two-bit counter then walks the four words of the aligned group around that base, and it steps only on edges where the advance input is low.

A write is self-timed. The lane enables and the data are captured on one edge and are committed at the burst address on the following edge. Each of the four 9-bit lanes (a data byte plus its parity bit) has its own active-low enable, and a global write overrides them. Output enable and snooze act on the read bus without waiting for the clock. Snooze also freezes the memory and the capture registers.

Top module: `fsb_sram`

## Requirements
- R1: When `pstrb_n` or `cstrb_n` is sampled low, `addr` becomes the burst base and the counter is cleared. From the next cycle the burst address equals that `addr`.
- R2: If both strobes are low together, `pstrb_n` wins. A cycle started by `pstrb_n` is always a read: `gw_n`, `bw_n` and `wdata` in that cycle change no word.
- R3: With no strobe low, `adv_n` sampled low steps the counter by one. `adv_n` sampled high holds the counter, so the same burst address is repeated.
- R4: The two lowest address bits follow the burst order and the upper bits stay at the base. With `burst_linear`=1 they go (base+n) mod 4. With `burst_linear`=0 they go base XOR n.
- R5: `rdata` shows the array word at the current burst address in the same cycle the address register takes it, with no added latency.
- R6: Lane i is bits [9i+8:9i] and is written when `bw_n[i]`=0. It is committed at the burst address on the edge after capture and is visible in the following cycle. Lanes whose enable is high keep their contents.
- R7: `gw_n`=0 writes all four lanes, whatever `bw_n` holds.
- R8: `oe_n`=1 forces `rdata` to all zeros at once, without waiting for a clock edge.
- R9: While `snooze`=1, `rdata` is all zeros, no word is written and the capture registers hold. A write captured before `snooze` rose is discarded.
- R10: `rst_n` sampled low (synchronous) sets the burst base and counter to 0 and drops any write requested on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 6 | Word address sampled by a strobe |
| pstrb_n | input | 1 | Processor-side burst start, active low, read only, has priority |
| cstrb_n | input | 1 | Controller-side burst start, active low |
| adv_n | input | 1 | Burst advance, active low |
| burst_linear | input | 1 | 1 = linear order, 0 = interleaved order |
| gw_n | input | 1 | Global write of all lanes, active low |
| bw_n | input | 4 | Per-lane write enables, active low |
| wdata | input | 36 | Write data, four 9-bit lanes |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| snooze | input | 1 | Power-down, active high, asynchronous |
| rdata | output | 36 | Read data, all zeros when disabled |

## Verification
The embedded properties check the following on every clock cycle:
- a strobe loads the base and clears the counter;
- the counter holds or steps exactly as `adv_n` dictates;
- a cycle started by the processor strobe never arms a write;
- a global write arms every lane;
- snooze leaves nothing armed.

Only the directed scenarios can show the rest:
- the full order of addresses in linear and interleaved bursts, including the wrap inside a group;
- merged byte-lane contents;
- the one-cycle commit of a write;
- the data actually preserved through snooze and through a reset that lands on a write request;
- the asynchronous zeroing of the bus.

// File: rtl/fsb_sram_pkg.sv
// Package: shared burst-order type and the beat-offset rule.
// Assumes bursts of four beats over the two lowest address bits.
package fsb_sram_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        ORD_INTERLEAVE = 1'b0,
        ORD_LINEAR     = 1'b1
    } burst_order_e;

    // Low address bits for beat n of a burst from base_lo.
    function automatic logic [BEAT_W-1:0] beat_offset(
        input logic [BEAT_W-1:0] base_lo,
        input logic [BEAT_W-1:0] n,
        input burst_order_e      order
    );
        logic [BEAT_W-1:0] r;
        if (order == ORD_LINEAR) r = BEAT_W'(base_lo + n);
        else                     r = base_lo ^ n;
        return r;
    endfunction

endpackage

// File: rtl/fsb_burst_seq.sv
// Burst sequencer: holds the burst base and the beat counter and forms the
// current burst address. Assumes ADDR_W > BEAT_W; snooze freezes the state.
module fsb_burst_seq
    import fsb_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snooze,
    input  logic [ADDR_W-1:0] addr,
    input  logic              pstrb_n,
    input  logic              cstrb_n,
    input  logic              adv_n,
    input  burst_order_e      order,
    output logic [ADDR_W-1:0] burst_addr
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] cnt_q;
    logic              start;

    // Either strobe starts a burst.
    assign start = !pstrb_n || !cstrb_n;

    // Load the base on a start, otherwise step on advance; freeze in snooze.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (!snooze) begin
            if (start) begin
                base_q <= addr;
                cnt_q  <= '0;
            end else if (!adv_n) begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    // Upper bits from the base, low bits by burst order.
    always_comb begin
        burst_addr = {base_q[ADDR_W-1 -: HI_W],
                      beat_offset(base_q[BEAT_W-1:0], cnt_q, order)};
    end

    assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !snooze) |=> (cnt_q == '0 && base_q == $past(addr)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && adv_n && !snooze) |=> ($stable(cnt_q) && $stable(base_q)));

    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !adv_n && !snooze) |=> (cnt_q == BEAT_W'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/fsb_wr_ctl.sv
// Write control capture: registers the lane enables and the write data for a
// self-timed commit on the next edge. Assumes processor-strobe cycles are reads.
module fsb_wr_ctl #(
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    snooze,
    input  logic                    pstrb_n,
    input  logic                    gw_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES-1:0]        wr_lanes_q,
    output logic [LANES*LANE_W-1:0] wdata_q
);
    // Capture lane enables and data; snooze and processor strobe arm nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_lanes_q <= '0;
            wdata_q    <= '0;
        end else if (snooze) begin
            wr_lanes_q <= '0;
        end else begin
            wdata_q <= wdata;
            if (!pstrb_n)   wr_lanes_q <= '0;
            else if (!gw_n) wr_lanes_q <= '1;
            else            wr_lanes_q <= ~bw_n;
        end
    end

    assert_pread_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstrb_n && !snooze) |=> (wr_lanes_q == '0));

    assert_global_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pstrb_n && !gw_n && !snooze) |=> (wr_lanes_q == {LANES{1'b1}}));

endmodule

// File: rtl/fsb_array.sv
// Storage array: combinational read at the addressed word and a lane-masked
// write on the clock edge. Assumes one address shared by read and write.
// Contents are not reset.
module fsb_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    snooze,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        wr_lanes,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata_raw
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int WORD_W = LANES * LANE_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] bit_mask;

    // Expand each lane enable across its lane bits.
    for (genvar i = 0; i < LANES; i++) begin : g_mask
        assign bit_mask[i*LANE_W +: LANE_W] = {LANE_W{wr_lanes[i]}};
    end

    // Merge enabled lanes into the addressed word unless snoozing.
    always_ff @(posedge clk) begin
        if (!snooze && (wr_lanes != '0)) begin
            mem[addr] <= (mem[addr] & ~bit_mask) | (wdata & bit_mask);
        end
    end

    // Flow-through read path.
    assign rdata_raw = mem[addr];

endmodule

// File: rtl/fsb_sram.sv
// Top: flow-through synchronous burst memory. Ties the sequencer, the write
// capture and the array together and gates the read bus with output enable
// and snooze. Assumes the reset is synchronous and active low.
module fsb_sram
    import fsb_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    pstrb_n,
    input  logic                    cstrb_n,
    input  logic                    adv_n,
    input  logic                    burst_linear,
    input  logic                    gw_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic                    oe_n,
    input  logic                    snooze,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int WORD_W = LANES * LANE_W;

    logic [ADDR_W-1:0] burst_addr;
    logic [LANES-1:0]  wr_lanes;
    logic [WORD_W-1:0] wdata_q;
    logic [WORD_W-1:0] rdata_raw;
    burst_order_e      order;

    // Map the mode pin onto the order type.
    assign order = burst_linear ? ORD_LINEAR : ORD_INTERLEAVE;

    fsb_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .snooze     (snooze),
        .addr       (addr),
        .pstrb_n    (pstrb_n),
        .cstrb_n    (cstrb_n),
        .adv_n      (adv_n),
        .order      (order),
        .burst_addr (burst_addr)
    );

    fsb_wr_ctl #(.LANES(LANES), .LANE_W(LANE_W)) u_wr (
        .clk        (clk),
        .rst_n      (rst_n),
        .snooze     (snooze),
        .pstrb_n    (pstrb_n),
        .gw_n       (gw_n),
        .bw_n       (bw_n),
        .wdata      (wdata),
        .wr_lanes_q (wr_lanes),
        .wdata_q    (wdata_q)
    );

    fsb_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
        .clk       (clk),
        .snooze    (snooze),
        .addr      (burst_addr),
        .wr_lanes  (wr_lanes),
        .wdata     (wdata_q),
        .rdata_raw (rdata_raw)
    );

    // Asynchronous output gating by output enable and snooze.
    assign rdata = (oe_n || snooze) ? '0 : rdata_raw;

    assert_snooze_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snooze |=> (wr_lanes == '0));

endmodule

// File: tb/fsb_sram_bench.sv
// Directed bench: one task per scenario, each checking its own results
// against a bench-side memory model.
module fsb_sram_bench;
    localparam int ADDR_W = 6;
    localparam int LANES  = 4;
    localparam int LANE_W = 9;
    localparam int W      = LANES * LANE_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [ADDR_W-1:0] addr;
    logic              pstrb_n, cstrb_n, adv_n, burst_linear, gw_n, oe_n, snooze;
    logic [LANES-1:0]  bw_n;
    logic [W-1:0]      wdata;
    logic [W-1:0]      rdata;

    logic [W-1:0] exp_mem [1 << ADDR_W];
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    fsb_sram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_fsb_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .pstrb_n(pstrb_n),
        .cstrb_n(cstrb_n), .adv_n(adv_n), .burst_linear(burst_linear),
        .gw_n(gw_n), .bw_n(bw_n), .wdata(wdata), .oe_n(oe_n),
        .snooze(snooze), .rdata(rdata)
    );

    function automatic logic [W-1:0] pat(input int a);
        return {9'(a * 3 + 1), 9'(a * 5 + 2), 9'(a * 7 + 3), 9'(a + 100)};
    endfunction

    // Inputs change 2 ns after an edge; checks happen at that point too.
    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic idle();
        pstrb_n = 1'b1; cstrb_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bw_n = '1; wdata = '0;
    endtask

    task automatic chk(input string req, input logic [W-1:0] exp);
        n_checks++;
        if (rdata !== exp) begin
            n_fail++;
            $display("FAIL %s: rdata actual=%h expected=%h", req, rdata, exp);
        end
    endtask

    // Full-word write through the controller strobe and global write.
    task automatic wr_word(input int a, input logic [W-1:0] d);
        idle(); cstrb_n = 1'b0; addr = ADDR_W'(a); gw_n = 1'b0; wdata = d;
        step();
        idle();
        step();
        exp_mem[a] = d;
    endtask

    // Start a read burst with the processor strobe.
    task automatic rd_start(input int a);
        idle(); pstrb_n = 1'b0; addr = ADDR_W'(a);
        step();
        idle();
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0; idle(); addr = '0; burst_linear = 1'b1; snooze = 1'b0; oe_n = 1'b1;
        step(); step();
        chk("R8 reset bus with oe_n high", '0);
        rst_n = 1'b1; oe_n = 1'b0;
        step();
    endtask

    task automatic t_global_write();
        foreach (exp_mem[i]) exp_mem[i] = 'x;
        wr_word(0, pat(0));
        chk("R7 word 0 written", pat(0));
        for (int a = 8; a < 12; a++) begin
            wr_word(a, pat(a));
            chk("R7 group word written", pat(a));
        end
        // gw_n low with bw_n all high still writes every lane (R7)
        idle(); cstrb_n = 1'b0; addr = 6'd5; gw_n = 1'b0; bw_n = '1; wdata = pat(5);
        step(); idle(); step();
        exp_mem[5] = pat(5);
        chk("R7 gw_n overrides bw_n", pat(5));
    endtask

    task automatic t_flow_read();
        rd_start(9);
        chk("R5 flow-through data in address cycle", exp_mem[9]);
        idle(); cstrb_n = 1'b0; addr = 6'd11;
        step(); idle();
        chk("R1 controller strobe loads base", exp_mem[11]);
    endtask

    task automatic t_linear_burst();
        burst_linear = 1'b1;
        rd_start(9);
        chk("R4 linear beat0", exp_mem[9]);
        adv_n = 1'b0; step(); chk("R4 linear beat1", exp_mem[10]);
        step(); chk("R4 linear beat2", exp_mem[11]);
        step(); chk("R4 linear wrap beat3", exp_mem[8]);
        adv_n = 1'b1; step(); chk("R3 hold repeats address", exp_mem[8]);
        step(); chk("R3 hold second cycle", exp_mem[8]);
    endtask

    task automatic t_interleave_burst();
        burst_linear = 1'b0;
        rd_start(10);
        chk("R4 interleaved beat0", exp_mem[10]);
        adv_n = 1'b0; step(); chk("R4 interleaved beat1", exp_mem[11]);
        step(); chk("R4 interleaved beat2", exp_mem[8]);
        step(); chk("R4 interleaved beat3", exp_mem[9]);
        idle(); burst_linear = 1'b1;
    endtask

    task automatic t_byte_write();
        logic [W-1:0] d;
        d = 36'h1_2345_6789 ^ pat(40);
        idle(); cstrb_n = 1'b0; addr = 6'd9; bw_n = 4'b1010; wdata = d;
        step();
        chk("R6 old data before commit", exp_mem[9]);
        idle(); step();
        exp_mem[9][8:0]   = d[8:0];
        exp_mem[9][26:18] = d[26:18];
        chk("R6 lanes 0 and 2 merged", exp_mem[9]);
        // burst write with advance: 12 then 13
        idle(); cstrb_n = 1'b0; addr = 6'd12; gw_n = 1'b0; wdata = pat(12);
        step();
        idle(); adv_n = 1'b0; gw_n = 1'b0; wdata = pat(13);
        step();
        idle(); step();
        exp_mem[12] = pat(12); exp_mem[13] = pat(13);
        chk("R6 burst write second beat", exp_mem[13]);
        rd_start(12);
        chk("R6 burst write first beat", exp_mem[12]);
    endtask

    task automatic t_priority();
        idle(); pstrb_n = 1'b0; cstrb_n = 1'b0; addr = 6'd8; gw_n = 1'b0;
        wdata = 36'hF_FFFF_FFFF;
        step();
        idle(); step();
        chk("R2 processor strobe ignores write", exp_mem[8]);
        step();
        chk("R2 word still unchanged", exp_mem[8]);
    endtask

    task automatic t_snooze();
        rd_start(9);
        snooze = 1'b1; gw_n = 1'b0; wdata = 36'h0_AAAA_5555;
        #1; chk("R9 snooze zeroes bus at once", '0);
        step(); step();
        chk("R9 bus zero during snooze", '0);
        idle(); snooze = 1'b0;
        #1; chk("R9 write blocked in snooze", exp_mem[9]);
        #1;
        // pending write captured, then snooze rises before commit
        gw_n = 1'b0; wdata = 36'h0_1234_4321;
        step();
        idle(); snooze = 1'b1;
        step();
        snooze = 1'b0;
        step();
        chk("R9 pending write discarded", exp_mem[9]);
    endtask

    task automatic t_oe_async();
        rd_start(11);
        #1; oe_n = 1'b1;
        #1; chk("R8 oe_n high zeroes bus", '0);
        oe_n = 1'b0;
        #1; chk("R8 oe_n low restores data", exp_mem[11]);
        step();
    endtask

    task automatic t_reset_mid();
        idle(); cstrb_n = 1'b0; addr = 6'd5;
        step();
        idle(); rst_n = 1'b0; gw_n = 1'b0; wdata = 36'h3_3333_3333;
        step();
        rst_n = 1'b1; idle();
        chk("R10 reset returns to address 0", exp_mem[0]);
        step();
        chk("R10 address 0 unchanged", exp_mem[0]);
        idle(); cstrb_n = 1'b0; addr = 6'd5;
        step(); idle();
        chk("R10 write on reset edge dropped", exp_mem[5]);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_global_write();
        t_flow_read();
        t_linear_burst();
        t_interleave_burst();
        t_byte_write();
        t_priority();
        t_snooze();
        t_oe_async();
        t_reset_mid();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule